// File: doc/BRIEF.md
# Converter Serial Output Sequencer

This block models the digital face of a slow delta-sigma style converter as seen from the device side. After the supply is reported good, it holds a power-on reset for a programmable number of system clocks. At the end of that reset it reads the clock pin, which a weak pull-up holds high unless something outside drives it low. The level it reads chooses between an internal-clock mode and an external-clock mode.

In internal-clock mode the block drives the clock pin itself. It runs a repeating cycle of conversion, sleep and result output. While a conversion runs, both the clock pin and the data pin are parked high as a busy flag. A conversion-done pulse captures the result word and pulls both lines low. After half a serial clock period the block emits a frame of 32 rising clock edges, presenting a zero end-of-conversion flag followed by the upper 31 result bits. Both lines then return high and the next conversion begins. In external-clock mode the block leaves the clock pin undriven, and this block does nothing further there.

Top module: `conv_serial_seq`

## Requirements
- R1: After `rst`, and on the clock edge that samples `power_good` low, `sck_oe` is 0, `sdo` is 1 and `mode_internal` is 0.
- R2: The reset phase lasts exactly `POR_CYCLES` clocks: if `power_good` is first sampled high at edge P0, the mode takes effect at edge P0+`POR_CYCLES` and not before.
- R3: Only the level of `sck_pin_in` sampled at the closing edge of the reset phase counts. A 1 selects internal mode (`mode_internal`=1, `sck_oe`=1) and a 0 selects external mode.
- R4: In internal mode, while converting, `sck_out` and `sdo` are both 1.
- R5: The edge that samples `conv_done` high during a conversion drives `sck_out` and `sdo` to 0. `sck_out` then stays low for `SCK_DIV/2` clocks (the sleep phase) before its first rise.
- R6: A frame has exactly 32 rising edges of `sck_out`, with period `SCK_DIV` clocks and 50% duty. Rise k comes `(2k-1)*SCK_DIV/2` clocks after the capturing edge and fall k comes `2k*SCK_DIV/2` clocks after it.
- R7: At rise 1, `sdo` is 0. At rise k (k = 2 to 32), `sdo` is bit 33-k of the `result_word` captured with `conv_done`, so the result goes out most significant bit first and bit 0 is never sent.
- R8: Within a frame, `sdo` changes only on clocks where `sck_out` falls.
- R9: One clock after the 32nd rise, `sdo` returns to 1. `sck_out` stays 1, no further rise occurs, and the block is converting again.
- R10: In external mode, `sck_oe` stays 0, `sdo` stays 1 and `conv_done` has no effect.
- R11: A `conv_done` pulse during a frame is ignored: the frame keeps its timing and the data captured at its start.
- R12: Dropping `power_good` leaves the selected mode; raising it again runs a new reset phase and a new mode selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| power_good | input | 1 | Supply above threshold |
| sck_pin_in | input | 1 | Sensed level of the serial clock pin |
| conv_done | input | 1 | Conversion finished strobe |
| result_word | input | 32 | Conversion result, captured with conv_done |
| sdo | output | 1 | Serial data pin level |
| sck_out | output | 1 | Driven serial clock level |
| sck_oe | output | 1 | Serial clock pin output enable |
| mode_internal | output | 1 | 1 when internal-clock mode is selected |

## Verification
Some properties are checked on every cycle. The busy parking of both lines during conversion, the undriven clock and high data line in external mode, and the power-down state are checked this way. So is the rule that data moves only on a falling clock, along with the bounds of the edge, half-period and reset counters. The exact reset length, the mode chosen from the sampled pin, the cycle position of each of the 32 edges, the bit order and the end-of-conversion flag can only be shown by the bench scenarios. The same holds for ignoring a mid-frame `conv_done` and for switching modes after a power cycle.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_POR   = 3'd1,
        ST_CONV  = 3'd2,
        ST_FRAME = 3'd3,
        ST_EXT   = 3'd4
    } seq_state_e;

    typedef enum logic {
        CLK_MODE_EXT = 1'b0,
        CLK_MODE_INT = 1'b1
    } clk_mode_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic idle;
    } shift_ctl_t;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/cs_por_ctrl.sv
module cs_por_ctrl
    import conv_seq_pkg::*;
#(
    parameter int unsigned POR_CYCLES = 125000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_pin_in,
    output logic      por_done,
    output clk_mode_e mode
);
    localparam int unsigned CW = cnt_bits(POR_CYCLES);

    logic          armed_q;
    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign por_done = busy_q && (cnt_q == CW'(POR_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            mode    <= CLK_MODE_EXT;
        end else if (!armed_q) begin
            armed_q <= 1'b1;
            busy_q  <= 1'b1;
            cnt_q   <= '0;
        end else if (busy_q) begin
            if (por_done) begin
                busy_q <= 1'b0;
                mode   <= clk_mode_e'(sck_pin_in);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_por_cnt_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(POR_CYCLES - 1));

endmodule

// File: rtl/cs_sck_gen.sv
module cs_sck_gen
    import conv_seq_pkg::*;
#(
    parameter int unsigned SCK_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int unsigned HALF = SCK_DIV / 2;
    localparam int unsigned HW   = cnt_bits(HALF);

    logic [HW-1:0] cnt_q;
    logic          wrap;

    assign wrap = run && (cnt_q == HW'(HALF - 1));
    assign rise = wrap && !sck;
    assign fall = wrap && sck;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck   <= 1'b1;
            cnt_q <= '0;
        end else if (start) begin
            sck   <= 1'b0;
            cnt_q <= '0;
        end else if (run) begin
            if (wrap) begin
                cnt_q <= '0;
                sck   <= ~sck;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            sck   <= 1'b1;
            cnt_q <= '0;
        end
    end

    p_half_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= HW'(HALF - 1));

    p_start_low_r5: assert property (@(posedge clk) disable iff (rst)
        start |=> !sck);

endmodule

// File: rtl/cs_shift_out.sv
module cs_shift_out
    import conv_seq_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl,
    input  logic [WORD_W-1:0] word,
    output logic              sdo
);
    logic [WORD_W-1:0] sh_q;
    logic              idle_q;

    assign sdo = idle_q | sh_q[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            idle_q <= 1'b1;
        end else if (ctl.load) begin
            sh_q   <= {1'b0, word[WORD_W-1:1]};
            idle_q <= 1'b0;
        end else if (ctl.idle) begin
            idle_q <= 1'b1;
        end else if (ctl.shift) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b1};
        end
    end

    p_load_flag_low_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> !sdo);

endmodule

// File: rtl/conv_serial_seq.sv
module conv_serial_seq
    import conv_seq_pkg::*;
#(
    parameter int unsigned POR_CYCLES = 125000,
    parameter int unsigned SCK_DIV    = 8,
    parameter int unsigned WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              power_good,
    input  logic              sck_pin_in,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] result_word,
    output logic              sdo,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              mode_internal
);
    localparam int unsigned EW = $clog2(WORD_W + 1);

    seq_state_e    st_q;
    logic          rst_int;
    logic          por_done;
    clk_mode_e     mode;
    logic [EW-1:0] rise_cnt_q;
    logic          frame_start, frame_run, frame_end;
    logic          sck_rise, sck_fall;
    shift_ctl_t    sh_ctl;

    assign rst_int     = rst || !power_good;
    assign frame_start = (st_q == ST_CONV) && conv_done;
    assign frame_end   = (st_q == ST_FRAME) && (rise_cnt_q == EW'(WORD_W));
    assign frame_run   = (st_q == ST_FRAME) && !frame_end;

    assign sh_ctl.load  = frame_start;
    assign sh_ctl.shift = sck_fall;
    assign sh_ctl.idle  = !frame_run;

    assign sck_oe        = (st_q == ST_CONV) || (st_q == ST_FRAME);
    assign mode_internal = (mode == CLK_MODE_INT);

    cs_por_ctrl #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk        (clk),
        .rst        (rst_int),
        .sck_pin_in (sck_pin_in),
        .por_done   (por_done),
        .mode       (mode)
    );

    cs_sck_gen #(.SCK_DIV(SCK_DIV)) u_sck (
        .clk   (clk),
        .rst   (rst_int),
        .start (frame_start),
        .run   (frame_run),
        .sck   (sck_out),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    cs_shift_out #(.WORD_W(WORD_W)) u_shift (
        .clk  (clk),
        .rst  (rst_int),
        .ctl  (sh_ctl),
        .word (result_word),
        .sdo  (sdo)
    );

    always_ff @(posedge clk) begin
        if (rst_int) begin
            st_q <= ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:   st_q <= ST_POR;
                ST_POR:   if (por_done) st_q <= sck_pin_in ? ST_CONV : ST_EXT;
                ST_CONV:  if (conv_done) st_q <= ST_FRAME;
                ST_FRAME: if (frame_end) st_q <= ST_CONV;
                ST_EXT:   st_q <= ST_EXT;
                default:  st_q <= ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst_int || frame_start) begin
            rise_cnt_q <= '0;
        end else if (sck_rise) begin
            rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    p_oe_off_r1: assert property (@(posedge clk) disable iff (rst)
        !power_good |=> (!sck_oe && sdo && !mode_internal));

    p_conv_parked_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV) |-> (sck_out && sdo));

    p_rise_bound_r6: assert property (@(posedge clk) disable iff (rst)
        rise_cnt_q <= EW'(WORD_W));

    p_sdo_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_FRAME) && ($past(st_q) == ST_FRAME) && (sdo != $past(sdo)))
            |-> $fell(sck_out));

    p_ext_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EXT) |-> (!sck_oe && sdo && !mode_internal));

endmodule

// File: tb/conv_serial_seq_bench.sv
module conv_serial_seq_bench;
    localparam int unsigned POR = 20;
    localparam int unsigned DIV = 6;
    localparam int unsigned H   = DIV / 2;

    logic        clk = 1'b0;
    logic        rst, power_good, sck_pin_in, conv_done;
    logic [31:0] result_word;
    logic        sdo, sck_out, sck_oe, mode_internal;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    conv_serial_seq #(.POR_CYCLES(POR), .SCK_DIV(DIV), .WORD_W(32)) u_conv_serial_seq (
        .clk(clk), .rst(rst), .power_good(power_good), .sck_pin_in(sck_pin_in),
        .conv_done(conv_done), .result_word(result_word), .sdo(sdo),
        .sck_out(sck_out), .sck_oe(sck_oe), .mode_internal(mode_internal)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [31:0] w, input int k);
        return (k == 1) ? 1'b0 : w[33-k];
    endfunction

    task automatic power_up(input logic pin);
        sck_pin_in = ~pin;
        power_good = 1'b1;
        repeat (POR) @(negedge clk);
        chk(!sck_oe && !mode_internal, "R2", {sck_oe, mode_internal}, 0);
        sck_pin_in = pin;
        @(negedge clk);
        chk(mode_internal == pin, "R3", mode_internal, pin);
        chk(sck_oe == pin, "R3", sck_oe, pin);
        sck_pin_in = 1'b1;
    endtask

    task automatic idle_conv(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(sck_out && sdo && sck_oe, "R4", {sck_oe, sck_out, sdo}, 3'b111);
        end
    endtask

    task automatic run_frame(input logic [31:0] word, input int mid_t, input logic [31:0] noise);
        int   rises = 0;
        int   falls = 0;
        logic prev_sck = 1'b1;
        logic prev_sdo = 1'b1;
        @(negedge clk);
        conv_done   = 1'b1;
        result_word = word;
        for (int t = 1; t <= 63*H + 6; t++) begin
            @(negedge clk);
            if (t == 1) conv_done = 1'b0;
            if (t == mid_t) begin conv_done = 1'b1; result_word = noise; end
            if (t == mid_t + 1) conv_done = 1'b0;
            if (t == 1) begin
                chk(!sck_out, "R5", sck_out, 0);
                chk(!sdo, "R5", sdo, 0);
            end
            if (sck_out && !prev_sck) begin
                rises++;
                chk(t == (2*rises - 1)*H + 1, "R6", t, (2*rises - 1)*H + 1);
                chk(sdo == exp_bit(word, rises), mid_t > 0 ? "R11" : "R7", sdo, exp_bit(word, rises));
            end
            if (!sck_out && prev_sck && t > 1) begin
                falls++;
                chk(t == 2*falls*H + 1, "R6", t, 2*falls*H + 1);
            end
            if (t >= 2 && t <= 63*H + 1 && sdo != prev_sdo)
                chk(prev_sck && !sck_out, "R8", {prev_sck, sck_out}, 2'b10);
            if (t == 63*H + 2)
                chk(sdo && sck_out, "R9", {sck_out, sdo}, 2'b11);
            prev_sck = sck_out;
            prev_sdo = sdo;
        end
        chk(rises == 32, "R9", rises, 32);
        chk(falls == 31, "R6", falls, 31);
        chk(sck_oe, "R9", sck_oe, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; power_good = 1'b0; sck_pin_in = 1'b1; conv_done = 1'b0; result_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sck_oe && sdo && !mode_internal, "R1", {sck_oe, sdo, mode_internal}, 3'b010);

        power_up(1'b1);
        idle_conv(5);
        run_frame(32'h0000_0000, 0, 0);
        idle_conv(2);
        run_frame(32'hFFFF_FFFF, 0, 0);
        run_frame(32'hAAAA_AAAA, 0, 0);
        run_frame(32'h5555_5555, 40, 32'h1234_5678);
        for (int i = 0; i < 6; i++) begin
            w = $urandom;
            idle_conv($urandom_range(0, 4));
            run_frame(w, (i % 2 == 1) ? int'($urandom_range(2, 63*H)) : 0, $urandom);
        end

        // R12 / R1: power drop returns to the off state
        @(negedge clk);
        power_good = 1'b0;
        @(negedge clk);
        chk(!sck_oe && sdo && !mode_internal, "R12", {sck_oe, sdo, mode_internal}, 3'b010);
        repeat (3) @(negedge clk);
        power_up(1'b0);
        for (int i = 0; i < 40; i++) begin
            conv_done = (i % 5 == 0);
            @(negedge clk);
            chk(!sck_oe && sdo && !mode_internal, "R10", {sck_oe, sdo, mode_internal}, 3'b010);
        end
        conv_done = 1'b0;

        // R12: back to internal mode after another power cycle
        power_good = 1'b0;
        repeat (2) @(negedge clk);
        power_up(1'b1);
        idle_conv(3);
        run_frame(32'hC3A5_0F81, 0, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule